// File: doc/BRIEF.md
# Flash Operation Access Guard

This block sits between the flash request sources and the flash controller's operation sequencer. It decides whether a program or page-erase request may go ahead. It holds two small registers that share one register-file address. The first is an 8-bit page-select register: the top bit picks the information area instead of main memory, and the low seven bits hold a page number. The second is an eight-bit sector-protect mask with one bit per 8 KB sector of a 64 KB program space.

Which of the two registers a shared-address write reaches depends on the flash control register. If the most recent write to the control register was the unlock code 0x5E, made while the controller reported itself locked, the write goes to the protect mask. In every other case it goes to page-select. The flash array, the pulse timing and the remaining unlock sequence are modelled only as a `locked` input.

Each request carries its source, either the CPU or the in-circuit programming port, together with its kind (program or erase) and a 16-bit address. One cycle after the request strobe, the block registers four results: an accept flag, the resolved page, whether the target is the information area, and a reason code that explains a rejection.

Top module: `flash_access_guard`

## Requirements
- R1: While `por_n` is low, page-select, the protect mask and the decision outputs are all zero. While `rst_n` is low, page-select and the decision outputs are zero, but the protect mask keeps its value.
- R2: A write on `sel_wr` reaches the protect mask only when the last `ctl_wr` carried 0x5E while `locked` was 1. In that case page-select is left unchanged. Otherwise the write loads page-select and leaves the mask unchanged. Any other `ctl_wr` disarms the steering, and so does a system reset.
- R3: A protect write sets every mask bit whose data bit is 1. A 0 in the data never clears a mask bit.
- R4: `dec_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. The decision is computed from the register values as they stood before any write in that same cycle.
- R5: When page-select bit 7 is 0, a CPU request whose sector, taken from address bits 15:13, has its mask bit set is rejected with reason 4. Otherwise the request is accepted with reason 0 and page equal to address bits 15:9.
- R6: A CPU request made while page-select bit 7 is 1 is rejected with reason 1, whatever its address or kind.
- R7: A programming-port request made while page-select bit 7 is 0 is accepted whatever the protect mask holds, with page equal to address bits 15:9.
- R8: A programming-port request made while page-select bit 7 is 1 is rejected with reason 2 unless page-select equals 0x83.
- R9: When page-select is 0x83, a programming-port program request is rejected with reason 3 unless address bits 12:6 equal page-select bits 6:0. A programming-port erase request skips this address check. An accepted information-area request reports page equal to page-select bits 1:0.
- R10: `dec_info` reports page-select bit 7 as it stood when the request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; the only reset that clears the protect mask |
| rst_n | input | 1 | System reset, active low, asynchronous |
| locked | input | 1 | Flash controller reports the locked state |
| ctl_wr | input | 1 | Write strobe for the flash control register |
| ctl_wdata | input | 8 | Data written to the flash control register |
| sel_wr | input | 1 | Write strobe for the shared page-select / protect address |
| sel_wdata | input | 8 | Data for the shared-address write |
| req_valid | input | 1 | Operation request strobe |
| req_src | input | 1 | Request source: 0 CPU, 1 programming port |
| req_erase | input | 1 | Request kind: 0 program, 1 page erase |
| req_addr | input | 16 | Program-space address of the request |
| page_sel_q | output | 8 | Current page-select register |
| prot_q | output | 8 | Current sector-protect mask |
| dec_valid | output | 1 | Decision present this cycle |
| dec_accept | output | 1 | Request accepted |
| dec_info | output | 1 | Request targeted the information area |
| dec_page | output | 7 | Resolved page number |
| dec_reason | output | 3 | 0 ok, 1 CPU to info area, 2 page-select key wrong, 3 info address mismatch, 4 sector protected |

## Verification
The assertions check the following on every cycle:
- the protect mask never loses a bit between power-on resets;
- a steered write leaves the other register untouched;
- the decision strobe follows the request by exactly one cycle;
- the rejection rules for the CPU and for a wrong information-area key hold.

Some behaviours depend on an ordering of writes and resets, and only the bench scenarios can show them. One is that a control write with the unlock code has no effect while the controller is unlocked. Another is that the protect mask survives a system reset but not a power-on reset. A third is the information-area address match, which is tested with both a matching and a mismatching row.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  parameter int ADDR_W   = 16;
  parameter int PAGE_W   = 7;
  parameter int SECT_W   = 3;
  parameter int REG_W    = 8;
  localparam int NSECT   = 1 << SECT_W;
  localparam int PAGE_LO = ADDR_W - PAGE_W;   // 9
  localparam int SECT_LO = ADDR_W - SECT_W;   // 13
  localparam int ROW_LO  = 6;

  localparam logic [REG_W-1:0] UNLOCK_CODE = 8'h5E;
  localparam logic [REG_W-1:0] INFO_KEY    = 8'h83;

  typedef enum logic [2:0] {
    RSN_OK        = 3'd0,
    RSN_CPU_INFO  = 3'd1,
    RSN_INFO_KEY  = 3'd2,
    RSN_INFO_ADDR = 3'd3,
    RSN_PROTECTED = 3'd4
  } reason_e;

  typedef struct packed {
    logic              accept;
    logic              info;
    logic [PAGE_W-1:0] page;
    reason_e           reason;
  } verdict_t;

  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SECT_LO];
  endfunction

  function automatic logic [PAGE_W-1:0] main_page(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_LO];
  endfunction

  function automatic logic [PAGE_W-1:0] info_row(input logic [ADDR_W-1:0] a);
    return a[ROW_LO+PAGE_W-1:ROW_LO];
  endfunction
endpackage

// File: rtl/fg_regs.sv
module fg_regs
  import flash_guard_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_n,
  input  logic             locked,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             sel_wr,
  input  logic [REG_W-1:0] sel_wdata,
  output logic [REG_W-1:0] page_sel,
  output logic [NSECT-1:0] prot
);
  logic arm;
  logic arm_hit, to_prot, to_ps;

  assign arm_hit = ctl_wr & locked & (ctl_wdata == UNLOCK_CODE);
  assign to_prot = sel_wr & arm;
  assign to_ps   = sel_wr & ~arm;

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      arm      <= 1'b0;
      page_sel <= '0;
    end else begin
      if (ctl_wr) arm <= arm_hit;
      if (to_ps)  page_sel <= sel_wdata;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       prot <= '0;
    else if (to_prot) prot <= prot | sel_wdata[NSECT-1:0];
  end

  p_sticky_r3: assert property (@(posedge clk) disable iff (!por_n)
    ((prot & $past(prot)) == $past(prot)));

  p_steer_hold_r2: assert property (@(posedge clk) disable iff (!sys_n)
    (sel_wr && arm) |=> $stable(page_sel));

  p_ps_load_r2: assert property (@(posedge clk) disable iff (!sys_n)
    (sel_wr && !arm) |=> (page_sel == $past(sel_wdata)) && $stable(prot));
endmodule

// File: rtl/fg_decide.sv
module fg_decide
  import flash_guard_pkg::*;
(
  input  logic              clk,
  input  logic              sys_n,
  input  logic              req_valid,
  input  logic              req_src,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  page_sel,
  input  logic [NSECT-1:0]  prot,
  output logic              dec_valid,
  output verdict_t          dec
);
  verdict_t nxt;
  logic     info_sel, key_ok, row_ok, sect_locked;

  assign info_sel    = page_sel[REG_W-1];
  assign key_ok      = (page_sel == INFO_KEY);
  assign row_ok      = (info_row(req_addr) == page_sel[PAGE_W-1:0]);
  assign sect_locked = prot[sector_of(req_addr)];

  always_comb begin
    nxt.info   = info_sel;
    nxt.accept = 1'b0;
    nxt.page   = main_page(req_addr);
    nxt.reason = RSN_OK;
    if (info_sel) begin
      nxt.page = {{(PAGE_W-2){1'b0}}, page_sel[1:0]};
      if (!req_src)                  nxt.reason = RSN_CPU_INFO;
      else if (!key_ok)              nxt.reason = RSN_INFO_KEY;
      else if (!req_erase && !row_ok) nxt.reason = RSN_INFO_ADDR;
      else                           nxt.accept = 1'b1;
    end else begin
      if (!req_src && sect_locked) nxt.reason = RSN_PROTECTED;
      else                         nxt.accept = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      dec_valid <= 1'b0;
      dec       <= '0;
    end else begin
      dec_valid <= req_valid;
      if (req_valid) dec <= nxt;
    end
  end

  p_valid_lag_r4: assert property (@(posedge clk) disable iff (!sys_n)
    req_valid |=> dec_valid);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!sys_n)
    !req_valid |=> !dec_valid);

  p_cpu_info_r6: assert property (@(posedge clk) disable iff (!sys_n)
    (req_valid && !req_src && page_sel[REG_W-1]) |=>
      (!dec.accept && dec.reason == RSN_CPU_INFO));

  p_key_r8: assert property (@(posedge clk) disable iff (!sys_n)
    (req_valid && req_src && page_sel[REG_W-1] && page_sel != INFO_KEY) |=>
      !dec.accept);

  p_protect_r5: assert property (@(posedge clk) disable iff (!sys_n)
    (req_valid && !req_src && !page_sel[REG_W-1] && prot[req_addr[ADDR_W-1:SECT_LO]]) |=>
      !dec.accept);

  p_port_main_r7: assert property (@(posedge clk) disable iff (!sys_n)
    (req_valid && req_src && !page_sel[REG_W-1]) |=> dec.accept);
endmodule

// File: rtl/flash_access_guard.sv
module flash_access_guard
  import flash_guard_pkg::*;
(
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        locked,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_wdata,
  input  logic        sel_wr,
  input  logic [7:0]  sel_wdata,
  input  logic        req_valid,
  input  logic        req_src,
  input  logic        req_erase,
  input  logic [15:0] req_addr,
  output logic [7:0]  page_sel_q,
  output logic [7:0]  prot_q,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        dec_info,
  output logic [6:0]  dec_page,
  output logic [2:0]  dec_reason
);
  logic     sys_n;
  verdict_t dec;

  assign sys_n = por_n & rst_n;

  fg_regs u_regs (
    .clk       (clk),
    .por_n     (por_n),
    .sys_n     (sys_n),
    .locked    (locked),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .sel_wr    (sel_wr),
    .sel_wdata (sel_wdata),
    .page_sel  (page_sel_q),
    .prot      (prot_q)
  );

  fg_decide u_decide (
    .clk       (clk),
    .sys_n     (sys_n),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_erase (req_erase),
    .req_addr  (req_addr),
    .page_sel  (page_sel_q),
    .prot      (prot_q),
    .dec_valid (dec_valid),
    .dec       (dec)
  );

  assign dec_accept = dec.accept;
  assign dec_info   = dec.info;
  assign dec_page   = dec.page;
  assign dec_reason = dec.reason;
endmodule

// File: tb/tb_flash_access_guard.sv
`timescale 1ns/1ps
module tb_flash_access_guard;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, locked = 1'b0;
  logic ctl_wr = 1'b0, sel_wr = 1'b0;
  logic [7:0] ctl_wdata = '0, sel_wdata = '0;
  logic req_valid = 1'b0, req_src = 1'b0, req_erase = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] page_sel_q, prot_q;
  logic dec_valid, dec_accept, dec_info;
  logic [6:0] dec_page;
  logic [2:0] dec_reason;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_access_guard dut (.*);

  // behavioural reference model
  int m_ps = 0, m_prot = 0, m_arm = 0;
  int m_dv = 0, m_acc = 0, m_inf = 0, m_pg = 0, m_rs = 0;

  always @(posedge clk) begin
    if (!por_n || !rst_n) begin
      if (!por_n) m_prot = 0;
      m_ps = 0; m_arm = 0; m_dv = 0; m_acc = 0; m_inf = 0; m_pg = 0; m_rs = 0;
    end else begin
      if (req_valid) begin
        int a;
        a = req_addr;
        m_inf = (m_ps >= 128);
        m_acc = 0; m_rs = 0;
        if (m_inf != 0) begin
          m_pg = m_ps % 4;
          if (req_src == 0) m_rs = 1;
          else if (m_ps != 131) m_rs = 2;
          else if (req_erase == 0 && ((a / 64) % 128) != (m_ps % 128)) m_rs = 3;
          else m_acc = 1;
        end else begin
          m_pg = a / 512;
          if (req_src == 0 && ((m_prot >> (a / 8192)) % 2) == 1) m_rs = 4;
          else m_acc = 1;
        end
      end
      m_dv = req_valid;
      if (sel_wr) begin
        if (m_arm != 0) m_prot = m_prot | sel_wdata;
        else m_ps = sel_wdata;
      end
      if (ctl_wr) m_arm = (locked && ctl_wdata == 8'h5E);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (por_n && rst_n && !done) begin
      check("R2 model page-select", page_sel_q, m_ps);
      check("R3 model protect", prot_q, m_prot);
      check("R4 model dec_valid", dec_valid, m_dv);
      if (dec_valid) begin
        check("R5 model accept", dec_accept, m_acc);
        check("R10 model info", dec_info, m_inf);
        check("R9 model page", dec_page, m_pg);
        check("R8 model reason", dec_reason, m_rs);
      end
    end
  end

  task automatic ctl_write(input logic [7:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic sel_write(input logic [7:0] d);
    @(negedge clk); sel_wr = 1; sel_wdata = d;
    @(negedge clk); sel_wr = 0;
  endtask

  task automatic request(input logic src, input logic erase, input logic [15:0] a,
                         input string tag, input int acc, input int rsn, input int pg);
    @(negedge clk); req_valid = 1; req_src = src; req_erase = erase; req_addr = a;
    @(negedge clk); req_valid = 0;
    check({tag, " valid"}, dec_valid, 1);
    check({tag, " accept"}, dec_accept, acc);
    check({tag, " reason"}, dec_reason, rsn);
    check({tag, " page"}, dec_page, pg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    check("R1 reset page-select", page_sel_q, 0);
    check("R1 reset protect", prot_q, 0);
    check("R4 idle no decision", dec_valid, 0);

    sel_write(8'h12);
    check("R2 plain write to page-select", page_sel_q, 8'h12);
    check("R2 plain write leaves protect", prot_q, 0);

    locked = 1;
    ctl_write(8'h5E);
    sel_write(8'h05);
    check("R2 armed write to protect", prot_q, 8'h05);
    check("R2 armed write leaves page-select", page_sel_q, 8'h12);
    sel_write(8'h02);
    check("R3 bits accumulate", prot_q, 8'h07);
    sel_write(8'h00);
    check("R3 zero does not clear", prot_q, 8'h07);

    locked = 0;
    ctl_write(8'h5E);
    sel_write(8'h00);
    check("R2 unlocked code disarms", page_sel_q, 8'h00);
    check("R2 unlocked code protect kept", prot_q, 8'h07);

    request(0, 0, 16'h0200, "R5 cpu protected sector", 0, 4, 1);
    request(0, 1, 16'h6000, "R5 cpu open sector", 1, 0, 7'h30);
    request(1, 0, 16'h0200, "R7 port ignores protect", 1, 0, 1);

    sel_write(8'h83);
    request(0, 1, 16'h00C0, "R6 cpu info erase", 0, 1, 3);
    check("R10 info flag", dec_info, 1);
    request(1, 0, 16'h00C0, "R9 port info row match", 1, 0, 3);
    request(1, 0, 16'h0100, "R9 port info row mismatch", 0, 3, 3);
    request(1, 1, 16'h1234, "R9 port info erase skips row", 1, 0, 3);

    sel_write(8'h81);
    request(1, 1, 16'h0040, "R8 port wrong key", 0, 2, 1);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 sys reset clears page-select", page_sel_q, 0);
    check("R1 sys reset keeps protect", prot_q, 8'h07);
    check("R10 main flag after reset", dec_info, 0);

    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    @(negedge clk);
    check("R1 power-on clears protect", prot_q, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule